// File: doc/BRIEF.md
# Dual-Bank Masked Interrupt Vectorizer

This block gathers sixteen interrupt request lines into one processor interrupt. Each line is edge-sensitive: a rising edge latches a sticky pending bit that stays set until software acknowledges the line's bank. The lines form two banks of eight. Each bank has an acknowledge byte and a mask byte on a small byte-wide register bus.

A 16-bit enable mask gates the pending bits. Software writes a bank's mask byte with 1 meaning "masked", and the block stores the inverted byte as enable bits. A vector register reports the lowest-numbered line that is both pending and enabled. This lets the interrupt handler dispatch without scanning. The combined interrupt output is high whenever any line is both pending and enabled.

The bank size, the bank count, the bus widths and the encoder structure are parameters. The defaults give sixteen lines in two banks, an 8-bit data bus and a 3-bit address.

Top module: `irq_vectorizer`

## Requirements
- R1: After reset all 16 enable bits are 1 and no line is pending. irq_out is low, both mask offsets read 0xFF, and the vector offset reads 0.
- R2: A change of irq_req[i] from low to high between two consecutive clock samples sets pending bit i at the second sample. The sampling register resets low. The bit stays set after the line falls. A line that is held high sets the bit only once.
- R3: A write to a mask offset stores the bitwise inverse of the written byte into that bank's eight enable bits, with effect from the write edge. Offset 1 is the low bank (lines 0-7) and offset 3 is the high bank (lines 8-15). A written 1 masks the line. The other bank's enable bits are unchanged.
- R4: A read of offset 1 or offset 3 returns enable bits 7..0, the low byte of the full mask, whichever bank is addressed.
- R5: A write of any data to an acknowledge offset clears every pending bit of that bank and no other. Offset 0 is the low bank and offset 2 is the high bank.
- R6: A rising edge that is sampled on the same clock edge as an acknowledge write to its bank still sets its pending bit.
- R7: A read of offset 4 returns the index (0-15) of the lowest bit set in pending AND enable. It returns 0 when no such bit is set.
- R8: irq_out is high exactly when pending AND enable is nonzero. It follows mask writes, acknowledge writes and new edges from the clock edge that registers them.
- R9: Reads of offsets 0, 2, 5, 6 and 7 return 0. Writes to offsets 5-7 change neither the enable mask nor the pending bits. bus_rdata is 0 when no read is selected, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Interrupt request lines, rising-edge sensitive |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench goes after the cases an encoder or bank split gets wrong.

Line 0 pending reads back as vector 0, which matches the empty answer, so irq_out is checked beside it. An encoder that picks the highest bit, or ignores the mask, shows up in a sweep of 64 pending and enable patterns.

An acknowledge that clears both banks, or that drops an edge arriving on the same clock edge, leaves the wrong vector in the other bank or loses line 10. A mask write that is not inverted, or that touches the other half, changes the readback and the vector. A level-sensitive capture re-pends a held line after acknowledge. Address aliasing in the unused offsets shows up as a changed mask.

// File: rtl/ivz_pkg.sv
package ivz_pkg;

   // Kind of register selected by a bus read
   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_ACK  = 2'd1,
      KIND_MASK = 2'd2,
      KIND_VEC  = 2'd3
   } rd_kind_e;

   // Each bank owns two consecutive offsets: acknowledge, then mask
   function automatic int ack_offset(input int bank);
      return 2 * bank;
   endfunction

   function automatic int mask_offset(input int bank);
      return 2 * bank + 1;
   endfunction

   function automatic int vec_offset(input int num_banks);
      return 2 * num_banks;
   endfunction

endpackage

// File: rtl/ivz_decode.sv
module ivz_decode
   import ivz_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 3
)(
   input  logic                 sel,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] ack_wr,
   output logic [NUM_BANKS-1:0] mask_wr,
   output logic                 spare_wr,
   output rd_kind_e             rd_kind
);

   localparam int NUM_OFFS = vec_offset(NUM_BANKS) + 1;

   logic [NUM_BANKS-1:0] hit_ack;
   logic [NUM_BANKS-1:0] hit_mask;
   logic                 hit_vec;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
      assign hit_ack[b]  = (addr == ADDR_W'(ack_offset(b)));
      assign hit_mask[b] = (addr == ADDR_W'(mask_offset(b)));
      assign ack_wr[b]   = sel & wr & hit_ack[b];
      assign mask_wr[b]  = sel & wr & hit_mask[b];
   end

   assign hit_vec  = (addr == ADDR_W'(vec_offset(NUM_BANKS)));
   assign spare_wr = sel & wr & ({{(32-ADDR_W){1'b0}}, addr} >= 32'(NUM_OFFS));

   always_comb begin
      rd_kind = KIND_NONE;
      if (sel && !wr) begin
         if (|hit_ack)       rd_kind = KIND_ACK;
         else if (|hit_mask) rd_kind = KIND_MASK;
         else if (hit_vec)   rd_kind = KIND_VEC;
      end
   end

endmodule

// File: rtl/ivz_bank.sv
module ivz_bank #(
   parameter int LINES = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req,
   input  logic             ack_wr,
   input  logic             mask_wr,
   input  logic [LINES-1:0] wmask,
   output logic [LINES-1:0] pend,
   output logic [LINES-1:0] enable
);

   logic [LINES-1:0] req_q;
   logic [LINES-1:0] rise;

   assign rise = req & ~req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend   <= '0;
         enable <= '1;
      end else begin
         req_q <= req;
         pend  <= (ack_wr ? '0 : pend) | rise;
         if (mask_wr)
            enable <= ~wmask;
      end
   end

   // R3
   mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (enable == ~$past(wmask)));

   // R3
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(enable));

   // R5
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && rise == '0) |=> (pend == '0));

   // R2
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_wr |=> (($past(pend) & ~pend) == '0));

   // R6
   edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

endmodule

// File: rtl/ivz_lowest.sv
module ivz_lowest #(
   parameter int TOTAL = 16,
   parameter int GROUP = 8,
   parameter int STYLE = 1,
   localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
)(
   input  logic [TOTAL-1:0] hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign any = |hits;

   if (STYLE == 0) begin : g_flat
      always_comb begin
         idx = '0;
         for (int k = TOTAL - 1; k >= 0; k--)
            if (hits[k]) idx = IDX_W'(k);
      end
   end else begin : g_grouped
      localparam int NGRP  = TOTAL / GROUP;
      localparam int LOC_W = (GROUP > 1) ? $clog2(GROUP) : 1;

      logic [NGRP-1:0][LOC_W-1:0] loc;
      logic [NGRP-1:0]            gany;

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         logic [GROUP-1:0] slice;
         logic [LOC_W-1:0] l;
         assign slice = hits[g*GROUP +: GROUP];
         always_comb begin
            l = '0;
            for (int k = GROUP - 1; k >= 0; k--)
               if (slice[k]) l = LOC_W'(k);
         end
         assign loc[g]  = l;
         assign gany[g] = |slice;
      end

      always_comb begin
         idx = '0;
         for (int g = NGRP - 1; g >= 0; g--)
            if (gany[g]) idx = IDX_W'(g * GROUP) + IDX_W'(loc[g]);
      end
   end

endmodule

// File: rtl/irq_vectorizer.sv
module irq_vectorizer
   import ivz_pkg::*;
#(
   parameter int LINES_PER_BANK = 8,
   parameter int NUM_BANKS      = 2,
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 3,
   parameter int ENC_STYLE      = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       irq_req,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   localparam int TOTAL    = LINES_PER_BANK * NUM_BANKS;
   localparam int IDX_W    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam int NUM_OFFS = vec_offset(NUM_BANKS) + 1;

   // Elaboration-time parameter checks
   if (TOTAL != 16)
      $error("irq_vectorizer: port width fixes the line count at 16");
   if (LINES_PER_BANK > DATA_W)
      $error("irq_vectorizer: a bank must fit in one data byte");
   if (IDX_W > DATA_W)
      $error("irq_vectorizer: vector index exceeds data width");
   if ((1 << ADDR_W) < NUM_OFFS)
      $error("irq_vectorizer: address too narrow for register window");
   if (ENC_STYLE != 0 && ENC_STYLE != 1)
      $error("irq_vectorizer: ENC_STYLE must be 0 or 1");

   logic [NUM_BANKS-1:0] ack_wr;
   logic [NUM_BANKS-1:0] mask_wr;
   logic                 spare_wr;
   rd_kind_e             rd_kind;

   logic [TOTAL-1:0] pend_all;
   logic [TOTAL-1:0] en_all;
   logic [TOTAL-1:0] hits;
   logic             enc_any;
   logic [IDX_W-1:0] enc_idx;
   logic [DATA_W-1:0] mask_rd;

   ivz_decode #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .sel      (bus_sel),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .ack_wr   (ack_wr),
      .mask_wr  (mask_wr),
      .spare_wr (spare_wr),
      .rd_kind  (rd_kind)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ivz_bank #(
         .LINES (LINES_PER_BANK)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (irq_req[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .ack_wr  (ack_wr[b]),
         .mask_wr (mask_wr[b]),
         .wmask   (bus_wdata[LINES_PER_BANK-1:0]),
         .pend    (pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .enable  (en_all[b*LINES_PER_BANK +: LINES_PER_BANK])
      );
   end

   assign hits = pend_all & en_all;

   ivz_lowest #(
      .TOTAL (TOTAL),
      .GROUP (LINES_PER_BANK),
      .STYLE (ENC_STYLE)
   ) u_enc (
      .hits (hits),
      .any  (enc_any),
      .idx  (enc_idx)
   );

   assign irq_out = enc_any;

   // Low byte of the full enable mask, zero-filled if the mask is narrower
   always_comb begin
      mask_rd = '0;
      for (int k = 0; k < DATA_W; k++)
         if (k < TOTAL) mask_rd[k] = en_all[k];
   end

   always_comb begin
      case (rd_kind)
         KIND_MASK: bus_rdata = mask_rd;
         KIND_VEC:  bus_rdata = enc_any ? DATA_W'(enc_idx) : '0;
         default:   bus_rdata = '0;
      endcase
   end

   // R7
   vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_any |-> (hits[enc_idx] &&
                   ((hits & ((TOTAL'(1) << enc_idx) - TOTAL'(1))) == '0)));

   // R9
   spare_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_wr && mask_wr == '0) |=> $stable(en_all));

   // R9
   spare_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_wr && ack_wr == '0) |=> (($past(pend_all) & ~pend_all) == '0));

endmodule

// File: tb/irq_vectorizer_test.sv
module irq_vectorizer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [15:0] m_pend;
   logic [15:0] m_en;
   logic [7:0]  rv;

   irq_vectorizer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (irq_req),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   always #10 clk = ~clk;

   function automatic int lowest(input logic [15:0] x);
      for (int k = 0; k < 16; k++)
         if (x[k]) return k;
      return 0;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] v);
      @(negedge clk);
      irq_req = v;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic set_mask(input logic [15:0] en);
      wr(3'd1, ~en[7:0]);
      wr(3'd3, ~en[15:8]);
      m_en = en;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_pend = '0;
      m_en = 16'hFFFF;

      // R1 reset state
      #1 chk(irq_out, 0, "R1 irq_out after reset");
      chk(bus_rdata, 0, "R1 rdata idle");
      rd(3'd1, rv); chk(rv, 8'hFF, "R1 low mask read");
      rd(3'd3, rv); chk(rv, 8'hFF, "R1 high mask read");
      rd(3'd4, rv); chk(rv, 0, "R1 vector read");

      // R2 / R7 walk each line alone, all lines enabled
      for (int i = 0; i < 16; i++) begin
         pulse(16'(1) << i);
         #1 chk(irq_out, 1, "R2 irq_out after single edge");
         rd(3'd4, rv); chk(rv, i, "R7 single line vector");
         wr(i < 8 ? 3'd0 : 3'd2, 8'h20);
         #1 chk(irq_out, 0, "R5 irq_out after bank ack");
      end

      // R2 held line sets once only
      @(negedge clk); irq_req[3] = 1'b1;
      @(negedge clk);
      rd(3'd4, rv); chk(rv, 3, "R2 held line pending");
      wr(3'd0, 8'h00);
      repeat (3) @(negedge clk);
      #1 chk(irq_out, 0, "R2 held line not re-pended");
      irq_req[3] = 1'b0;
      pulse(16'h0008);
      rd(3'd4, rv); chk(rv, 3, "R2 new edge after release");
      wr(3'd0, 8'hFF);

      // R5 ack clears only its own bank
      pulse(16'h0480);
      rd(3'd4, rv); chk(rv, 7, "R7 two banks pending");
      wr(3'd0, 8'h5A);
      rd(3'd4, rv); chk(rv, 10, "R5 low ack keeps high bank");
      wr(3'd2, 8'h00);
      #1 chk(irq_out, 0, "R5 high ack clears high bank");

      // R6 edge coincident with ack of its bank
      pulse(16'h1200);
      @(negedge clk);
      irq_req[10] = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h20;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; irq_req[10] = 1'b0;
      rd(3'd4, rv); chk(rv, 10, "R6 coincident edge kept");
      wr(3'd2, 8'h20);

      // R3 / R4 / R8 mask handling
      wr(3'd1, 8'h0F);
      rd(3'd1, rv); chk(rv, 8'hF0, "R3 low mask inverted");
      rd(3'd3, rv); chk(rv, 8'hF0, "R4 high offset returns low byte");
      wr(3'd3, 8'hA5);
      rd(3'd1, rv); chk(rv, 8'hF0, "R3 low half unchanged");
      pulse(16'hFFFF);
      rd(3'd4, rv); chk(rv, 4, "R3 vector under mixed mask");
      wr(3'd1, 8'hFF);
      rd(3'd4, rv); chk(rv, 9, "R3 high half enables 0x5A");
      wr(3'd3, 8'hFF);
      #1 chk(irq_out, 0, "R8 irq_out drops on full mask");
      rd(3'd4, rv); chk(rv, 0, "R7 vector 0 when masked");
      wr(3'd1, 8'hFE);
      #1 chk(irq_out, 1, "R8 irq_out rises on unmask of line 0");
      rd(3'd4, rv); chk(rv, 0, "R7 line 0 vector");

      // R9 spare offsets and non-register reads
      for (int a = 5; a < 8; a++) begin
         wr(3'(a), 8'h00);
         rd(3'(a), rv); chk(rv, 0, "R9 spare offset reads 0");
      end
      rd(3'd1, rv); chk(rv, 8'h01, "R9 mask unchanged by spare writes");
      rd(3'd4, rv); chk(rv, 0, "R9 pending unchanged by spare writes");
      #1 chk(irq_out, 1, "R9 irq_out unchanged");
      rd(3'd0, rv); chk(rv, 0, "R9 low ack offset reads 0");
      rd(3'd2, rv); chk(rv, 0, "R9 high ack offset reads 0");
      rd(3'd4, rv); chk(rv, 0, "R9 repeated read no side effect");
      #1 chk(irq_out, 1, "R9 irq_out after reads");
      wr(3'd0, 8'h20);
      wr(3'd2, 8'h20);

      // R7 / R8 / R5 sweep of pending and enable patterns
      for (int p = 0; p < 64; p++) begin
         logic [15:0] a;
         logic [15:0] e;
         a = 16'((p * 40503 + 7) ^ (p << 9));
         e = 16'((p * p * 2654435) ^ 16'hC3A5);
         set_mask(e);
         pulse(a);
         m_pend = a;
         #1 chk(irq_out, |(m_pend & m_en), "R8 sweep irq_out");
         rd(3'd4, rv); chk(rv, lowest(m_pend & m_en), "R7 sweep vector");
         wr(3'd0, 8'(p));
         m_pend = m_pend & 16'hFF00;
         #1 chk(irq_out, |(m_pend & m_en), "R8 sweep irq_out after low ack");
         rd(3'd4, rv); chk(rv, lowest(m_pend & m_en), "R5 sweep vector after low ack");
         rd(3'd3, rv); chk(rv, m_en[7:0], "R4 sweep mask readback");
         wr(3'd2, 8'(p));
         m_pend = '0;
         #1 chk(irq_out, 0, "R5 sweep irq_out after both acks");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule